// File: doc/BRIEF.md
# Peripheral interrupt status aggregator

This block is a secondary 32-bit interrupt status register. It collects five request conditions into one readable word. The conditions are a keypad press, a serial receive FIFO that has reached its fill threshold, a serial transmit FIFO that is running low, a UART transmit-ready condition and a UART receive request. Each condition is derived from level, enable and mode inputs supplied by neighbouring blocks.

The keypad condition is latched and is released by a write to a dedicated acknowledge address. The FIFO-based conditions follow occupancy thresholds. Each of them has its own clear rule, so none of them is a write-one-to-clear bit. The serial enables are resynchronised on a serial clock tick before they take effect.

A mask register selects which status bits drive the single active-high interrupt output. The raw status remains readable whatever the mask holds. All logic runs on one clock with an active-low synchronous reset.

Top module: `irq_status_agg`

## Requirements
- R1: During and just after reset, the status word, the mask and irq_out are all zero. Both serial sides count as disabled until a tick samples their enables.
- R2: The keypad condition is the OR of key_in[5:0] when key_short is 1 and the OR of key_in[7:0] when key_short is 0. A single-cycle high pulse sets status bit 0 at that clock edge. In short mode, key_in[7:6] are ignored.
- R3: Status bit 0 stays set until a write to address 2. If a write to address 2 and a press fall in the same cycle, the press wins.
- R4: Status bit 1 sets at the edge where ss_rx_level is 8 or more. It then holds while the level is between 1 and 7.
- R5: Status bit 1 clears at the edge where ss_rx_level is 0.
- R6: ss_rx_en and ss_tx_en are sampled only at edges where ss_tick is high. A disable sampled at edge e forces its status bit to 0 from edge e+1, and it stays 0 until a tick samples the enable high again.
- R7: Status bit 2 is registered from (ss_tx_level < 8) while the transmit side is enabled. It therefore clears at the edge where the level is 8 or more.
- R8: With uart_fifo_en at 0, status bit 12 follows uart_thr_empty one edge later.
- R9: With uart_fifo_en at 1, status bit 12 is 1 when uart_tx_level < 8 and 0 when it is 8 or more, one edge later.
- R10: Status bit 13 follows uart_rx_req one edge later.
- R11: A read at address 0 returns the status word, with all bits other than 0, 1, 2, 12 and 13 read as zero. A read at address 1 returns the mask. Writes to address 0 have no effect.
- R12: A write to address 1 stores only bits 0, 1, 2, 12 and 13 of the data. irq_out is high exactly when some status bit has its mask bit set. The raw status stays readable while it is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_in | input | 8 | Raw keypad lines, not filtered |
| key_short | input | 1 | 1: only the low 6 keypad lines count |
| ss_rx_level | input | 5 | Serial receive FIFO occupancy |
| ss_rx_en | input | 1 | Serial receive enable |
| ss_tx_level | input | 5 | Serial transmit FIFO occupancy |
| ss_tx_en | input | 1 | Serial transmit enable |
| ss_tick | input | 1 | Serial clock tick that samples the enables |
| uart_fifo_en | input | 1 | UART transmit FIFO mode select |
| uart_tx_level | input | 5 | UART transmit FIFO occupancy |
| uart_thr_empty | input | 1 | UART single holding register empty |
| uart_rx_req | input | 1 | UART receive request level |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 1 | Combined masked interrupt request |

## Verification
Every status bit is registered, so a source change is visible one rising edge later. The serial disable is the exception: it needs the tick edge plus one more, and the bench checks that the bit is still set after the first of those edges and cleared after the second. The bench drives inputs on the falling edge and reads results at the following falling edge. It samples the combinational read data and irq_out 1 ns after setting the address, so each check lands in the exact cycle its result is due.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int KBD_BIT = 0;
    localparam int SRX_BIT = 1;
    localparam int STX_BIT = 2;
    localparam int UTX_BIT = 12;
    localparam int URX_BIT = 13;
    localparam int WORD_W  = 32;

    localparam logic [WORD_W-1:0] IMPL_BITS =
        (WORD_W'(1) << KBD_BIT) | (WORD_W'(1) << SRX_BIT) |
        (WORD_W'(1) << STX_BIT) | (WORD_W'(1) << UTX_BIT) |
        (WORD_W'(1) << URX_BIT);

    typedef struct packed {
        logic [WORD_W-1:0] mask;
    } agg_regs_t;
endpackage

// File: rtl/irq_kbd_latch.sv
module irq_kbd_latch #(
    parameter int KEY_W   = 8,
    parameter int SHORT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_in,
    input  logic             key_short,
    input  logic             ack,
    output logic             pend
);
    typedef struct packed {
        logic pend;
    } kbd_st_t;

    kbd_st_t st_d, st_q;
    logic    hit;

    generate
        if (SHORT_W < KEY_W) begin : g_sel
            assign hit = key_short ? (|key_in[SHORT_W-1:0]) : (|key_in);
        end else begin : g_full
            logic unused_short;
            assign unused_short = key_short;
            assign hit = |key_in;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (ack) st_d.pend = 1'b0;
        if (hit) st_d.pend = 1'b1;   // a new press outranks the acknowledge
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/irq_ssi_flags.sv
module irq_ssi_flags #(
    parameter int DEPTH = 16,
    parameter int THR   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(DEPTH+1)-1:0]   rx_level,
    input  logic                         rx_en,
    input  logic [$clog2(DEPTH+1)-1:0]   tx_level,
    input  logic                         tx_en,
    input  logic                         tick,
    output logic                         rx_flag,
    output logic                         tx_flag
);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [LVL_W-1:0] THR_L = LVL_W'(THR);

    typedef struct packed {
        logic rx_off;
        logic tx_off;
        logic rx_flag;
        logic tx_flag;
    } ssi_st_t;

    ssi_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.rx_off = ~rx_en;
            st_d.tx_off = ~tx_en;
        end
        if (st_q.rx_off)              st_d.rx_flag = 1'b0;
        else if (rx_level >= THR_L)   st_d.rx_flag = 1'b1;
        else if (rx_level == '0)      st_d.rx_flag = 1'b0;
        st_d.tx_flag = ~st_q.tx_off & (tx_level < THR_L);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{rx_off: 1'b1, tx_off: 1'b1, rx_flag: 1'b0, tx_flag: 1'b0};
        else        st_q <= st_d;
    end

    assign rx_flag = st_q.rx_flag;
    assign tx_flag = st_q.tx_flag;
endmodule

// File: rtl/irq_uart_flags.sv
module irq_uart_flags #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_en,
    input  logic [$clog2(DEPTH+1)-1:0]   tx_level,
    input  logic                         thr_empty,
    input  logic                         rx_req,
    output logic                         tx_flag,
    output logic                         rx_flag
);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [LVL_W-1:0] HALF_L = LVL_W'(DEPTH / 2);

    typedef struct packed {
        logic tx_flag;
        logic rx_flag;
    } uart_st_t;

    uart_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.tx_flag = fifo_en ? (tx_level < HALF_L) : thr_empty;
        st_d.rx_flag = rx_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_flag = st_q.tx_flag;
    assign rx_flag = st_q.rx_flag;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int STATUS_ADDR  = 0,
    parameter int MASK_ADDR    = 1,
    parameter int KEY_EOI_ADDR = 2,
    parameter int KEY_W        = 8,
    parameter int SHORT_W      = 6,
    parameter int SS_DEPTH     = 16,
    parameter int SS_THR       = 8,
    parameter int UART_DEPTH   = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [KEY_W-1:0]                 key_in,
    input  logic                             key_short,
    input  logic [$clog2(SS_DEPTH+1)-1:0]    ss_rx_level,
    input  logic                             ss_rx_en,
    input  logic [$clog2(SS_DEPTH+1)-1:0]    ss_tx_level,
    input  logic                             ss_tx_en,
    input  logic                             ss_tick,
    input  logic                             uart_fifo_en,
    input  logic [$clog2(UART_DEPTH+1)-1:0]  uart_tx_level,
    input  logic                             uart_thr_empty,
    input  logic                             uart_rx_req,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic                             bus_wr,
    input  logic [WORD_W-1:0]                bus_wdata,
    output logic [WORD_W-1:0]                bus_rdata,
    output logic                             irq_out
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
    localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(KEY_EOI_ADDR);

    agg_regs_t         regs_d, regs_q;
    logic [WORD_W-1:0] stat_vec;
    logic              kbd_ack;
    logic              kbd_pend, srx_flag, stx_flag, utx_flag, urx_flag;

    assign kbd_ack = bus_wr && (bus_addr == A_EOI);

    irq_kbd_latch #(.KEY_W(KEY_W), .SHORT_W(SHORT_W)) u_kbd (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_in    (key_in),
        .key_short (key_short),
        .ack       (kbd_ack),
        .pend      (kbd_pend)
    );

    irq_ssi_flags #(.DEPTH(SS_DEPTH), .THR(SS_THR)) u_ssi (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_level (ss_rx_level),
        .rx_en    (ss_rx_en),
        .tx_level (ss_tx_level),
        .tx_en    (ss_tx_en),
        .tick     (ss_tick),
        .rx_flag  (srx_flag),
        .tx_flag  (stx_flag)
    );

    irq_uart_flags #(.DEPTH(UART_DEPTH)) u_uart (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (uart_fifo_en),
        .tx_level  (uart_tx_level),
        .thr_empty (uart_thr_empty),
        .rx_req    (uart_rx_req),
        .tx_flag   (utx_flag),
        .rx_flag   (urx_flag)
    );

    always_comb begin
        stat_vec          = '0;
        stat_vec[KBD_BIT] = kbd_pend;
        stat_vec[SRX_BIT] = srx_flag;
        stat_vec[STX_BIT] = stx_flag;
        stat_vec[UTX_BIT] = utx_flag;
        stat_vec[URX_BIT] = urx_flag;
    end

    always_comb begin
        regs_d = regs_q;
        if (bus_wr && (bus_addr == A_MASK)) regs_d.mask = bus_wdata & IMPL_BITS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        if (bus_addr == A_STAT)      bus_rdata = stat_vec;
        else if (bus_addr == A_MASK) bus_rdata = regs_q.mask;
        else                         bus_rdata = '0;
    end

    assign irq_out = |(stat_vec & regs_q.mask);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int KEY_EOI_ADDR = 2,
    parameter int KEY_W        = 8,
    parameter int SHORT_W      = 6,
    parameter int SS_DEPTH     = 16,
    parameter int SS_THR       = 8,
    parameter int UART_DEPTH   = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [KEY_W-1:0]                 key_in,
    input logic                             key_short,
    input logic                             bus_wr,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [$clog2(SS_DEPTH+1)-1:0]    ss_rx_level,
    input logic [$clog2(SS_DEPTH+1)-1:0]    ss_tx_level,
    input logic                             uart_fifo_en,
    input logic [$clog2(UART_DEPTH+1)-1:0]  uart_tx_level,
    input logic [WORD_W-1:0]                status
);
    localparam int SL_W = $clog2(SS_DEPTH+1);
    localparam int UL_W = $clog2(UART_DEPTH+1);
    localparam logic [SL_W-1:0]   SS_THR_L = SL_W'(SS_THR);
    localparam logic [UL_W-1:0]   U_HALF_L = UL_W'(UART_DEPTH / 2);
    localparam logic [ADDR_W-1:0] A_EOI    = ADDR_W'(KEY_EOI_ADDR);

    logic press, ack;
    assign press = key_short ? (|key_in[SHORT_W-1:0]) : (|key_in);
    assign ack   = bus_wr && (bus_addr == A_EOI);

    assert_press_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> status[KBD_BIT]);

    assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[KBD_BIT] && !ack) |=> status[KBD_BIT]);

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !press) |=> !status[KBD_BIT]);

    assert_rx_empty_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_rx_level == '0) |=> !status[SRX_BIT]);

    assert_tx_refill_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_tx_level >= SS_THR_L) |=> !status[STX_BIT]);

    assert_uart_fill_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_fifo_en && (uart_tx_level >= U_HALF_L)) |=> !status[UTX_BIT]);
endmodule

bind irq_status_agg irq_agg_chk #(
    .ADDR_W(ADDR_W), .KEY_EOI_ADDR(KEY_EOI_ADDR), .KEY_W(KEY_W), .SHORT_W(SHORT_W),
    .SS_DEPTH(SS_DEPTH), .SS_THR(SS_THR), .UART_DEPTH(UART_DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .key_in        (key_in),
    .key_short     (key_short),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .ss_rx_level   (ss_rx_level),
    .ss_tx_level   (ss_tx_level),
    .uart_fifo_en  (uart_fifo_en),
    .uart_tx_level (uart_tx_level),
    .status        (stat_vec)
);

// File: tb/sim_irq_status_agg.sv
`timescale 1ns/1ps
module sim_irq_status_agg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  key_in;
    logic        key_short;
    logic [4:0]  ss_rx_level, ss_tx_level, uart_tx_level;
    logic        ss_rx_en, ss_tx_en, ss_tick;
    logic        uart_fifo_en, uart_thr_empty, uart_rx_req;
    logic [3:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_status_agg u0 (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .key_short(key_short),
        .ss_rx_level(ss_rx_level), .ss_rx_en(ss_rx_en),
        .ss_tx_level(ss_tx_level), .ss_tx_en(ss_tx_en), .ss_tick(ss_tick),
        .uart_fifo_en(uart_fifo_en), .uart_tx_level(uart_tx_level),
        .uart_thr_empty(uart_thr_empty), .uart_rx_req(uart_rx_req),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 4'd0;
    endtask

    task automatic stat_bit(input string req, input int b, input logic exp);
        logic [31:0] v;
        rd(4'd0, v);
        chk(req, {31'd0, v[b]}, {31'd0, exp});
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0; bus_addr = 4'd0; bus_wdata = '0;
    endtask

    task automatic tick_once();
        ss_tick = 1'b1;
        step(1);
        ss_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v); chk("R1 status", v, 32'h0);
        rd(4'd1, v); chk("R1 mask", v, 32'h0);
        chk("R1 irq", {31'd0, irq_out}, 32'h0);
    endtask

    task automatic t_keypad();
        key_short = 1'b1; key_in = 8'hC0; step(1); key_in = 8'h00;
        stat_bit("R2 short mode ignores high lines", 0, 1'b0);
        key_in = 8'h04; step(1); key_in = 8'h00;
        stat_bit("R2 pulse sets", 0, 1'b1);
        step(3);
        stat_bit("R3 latch holds", 0, 1'b1);
        wr(4'd2, 32'h0);
        stat_bit("R3 ack clears", 0, 1'b0);
        key_short = 1'b0; key_in = 8'h80; step(1); key_in = 8'h00;
        stat_bit("R2 full mode uses line 7", 0, 1'b1);
        wr(4'd2, 32'h0);
        key_in = 8'h01; bus_addr = 4'd2; bus_wr = 1'b1; step(1);
        bus_wr = 1'b0; bus_addr = 4'd0; key_in = 8'h00;
        stat_bit("R3 press wins over ack", 0, 1'b1);
        wr(4'd2, 32'h0);
        stat_bit("R3 ack after tie", 0, 1'b0);
    endtask

    task automatic t_serial_rx();
        ss_rx_en = 1'b1; ss_tx_en = 1'b0; ss_tx_level = 5'd8;
        tick_once();
        ss_rx_level = 5'd7; step(1);
        stat_bit("R4 below threshold", 1, 1'b0);
        ss_rx_level = 5'd8; step(1);
        stat_bit("R4 at threshold", 1, 1'b1);
        ss_rx_level = 5'd3; step(1);
        stat_bit("R4 holds while nonempty", 1, 1'b1);
        ss_rx_level = 5'd0; step(1);
        stat_bit("R5 empty clears", 1, 1'b0);
        ss_rx_level = 5'd16; step(1);
        ss_rx_en = 1'b0; step(2);
        stat_bit("R6 enable ignored without tick", 1, 1'b1);
        tick_once();
        stat_bit("R6 still set on tick edge", 1, 1'b1);
        step(1);
        stat_bit("R6 disable clears", 1, 1'b0);
        ss_rx_en = 1'b1; step(1);
        stat_bit("R6 stays clear until tick", 1, 1'b0);
        tick_once(); step(1);
        stat_bit("R6 re-enable", 1, 1'b1);
        ss_rx_level = 5'd0; step(1);
    endtask

    task automatic t_serial_tx();
        ss_tx_level = 5'd0; step(1);
        stat_bit("R6 tx disabled keeps clear", 2, 1'b0);
        ss_tx_en = 1'b1; tick_once(); step(1);
        stat_bit("R7 low level sets", 2, 1'b1);
        ss_tx_level = 5'd8; step(1);
        stat_bit("R7 refill clears", 2, 1'b0);
        ss_tx_level = 5'd7; step(1);
        stat_bit("R7 below eight sets", 2, 1'b1);
        ss_tx_en = 1'b0; tick_once();
        stat_bit("R6 tx still set on tick edge", 2, 1'b1);
        step(1);
        stat_bit("R6 tx disable clears", 2, 1'b0);
    endtask

    task automatic t_uart();
        uart_fifo_en = 1'b0; uart_thr_empty = 1'b1; step(1);
        stat_bit("R8 holding empty", 12, 1'b1);
        uart_thr_empty = 1'b0; step(1);
        stat_bit("R8 holding written", 12, 1'b0);
        uart_fifo_en = 1'b1; uart_tx_level = 5'd7; step(1);
        stat_bit("R9 fifo below half", 12, 1'b1);
        uart_tx_level = 5'd8; step(1);
        stat_bit("R9 fifo half full", 12, 1'b0);
        uart_tx_level = 5'd0; step(1);
        stat_bit("R9 fifo empty", 12, 1'b1);
        uart_tx_level = 5'd16; step(1);
        stat_bit("R9 fifo full", 12, 1'b0);
        uart_rx_req = 1'b1; step(1);
        stat_bit("R10 rx request", 13, 1'b1);
        uart_rx_req = 1'b0; step(1);
        stat_bit("R10 rx release", 13, 1'b0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, v); chk("R12 mask keeps implemented bits", v, 32'h0000_3007);
        wr(4'd1, 32'h0);
        key_in = 8'h02; uart_rx_req = 1'b1; step(1); key_in = 8'h00;
        chk("R12 masked irq low", {31'd0, irq_out}, 32'h0);
        rd(4'd0, v); chk("R11 raw status readable", v, 32'h0000_2001);
        wr(4'd0, 32'h0);
        rd(4'd0, v); chk("R11 status write ignored", v, 32'h0000_2001);
        wr(4'd1, 32'h0000_0004);
        chk("R12 unrelated mask bit", {31'd0, irq_out}, 32'h0);
        wr(4'd1, 32'h0000_0001);
        chk("R12 mask enables irq", {31'd0, irq_out}, 32'h1);
        wr(4'd2, 32'h0);
        chk("R12 irq drops with status", {31'd0, irq_out}, 32'h0);
        uart_rx_req = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; key_in = '0; key_short = 1'b0;
        ss_rx_level = '0; ss_tx_level = '0; ss_rx_en = 1'b0; ss_tx_en = 1'b0; ss_tick = 1'b0;
        uart_fifo_en = 1'b0; uart_tx_level = '0; uart_thr_empty = 1'b0; uart_rx_req = 1'b0;
        bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        step(4);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_keypad();
        t_serial_rx();
        t_serial_tx();
        t_uart();
        t_regs();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule